// File: doc/BRIEF.md
# Counting Semaphore Controller

This block is a register-mapped counting semaphore that hardware and software threads share. It holds a resource count. A thread asks for N resources by writing N to the take register. One clock later the block makes a trial subtraction against the count. When enough resources remain, it stores the reduced count and raises a one-bit grant. Otherwise it leaves the count alone and the grant stays low. The thread then reads the grant register, and that read also clears the grant. A thread hands resources back by writing to the give register. The give register needs no lock, and a give does not alter a grant that is waiting to be read.

The write of a take and the read of its grant must be one atomic pair. A small binary lock keeps that pair free of interference from other threads. A thread acquires the lock by writing its id to the lock-request register. It then reads the owner register to learn whether it won. It frees the lock by writing the same id to the lock-release register. Software can reload the count at any time through the count register, with no reset.

The block sits on a simple single-port register bus. The bus takes one access per cycle and never stalls, so there is no back-pressure. Read data returns one cycle after the read is accepted.

Top module: `cnt_sema_ctrl`

## Requirements
- R1: After reset the count equals INIT_COUNT (default 4), the lock owner reads 0, the grant reads 0, the overflow status reads 0 and bus_rvalid is 0.
- R2: A read accepted at a clock edge (bus_en=1, bus_wr=0) drives bus_rvalid=1 and bus_rdata from the next edge onward for one cycle. A write drives bus_rvalid=0. Read map: address 1 is the owner, address 4 the grant in bit 0, address 6 the count and address 7 the overflow flag in bit 0. Other addresses read 0.
- R3: A write of a non-zero id to address 0 makes that id the owner only while the owner is 0 (free). While the lock is held, the write is ignored.
- R4: A write to address 2 frees the lock (owner becomes 0) only when the written id equals the current owner. Any other id is ignored.
- R5: A write of N to address 3 latches N. At the next edge, if N is not above the count, the count drops by N and the grant becomes 1. Otherwise the count is unchanged and the grant is 0.
- R6: A read of address 4 returns the grant and clears it to 0. A grant read accepted in the cycle right after the take write returns the result of that take.
- R7: Once the grant is set, it keeps its value across give writes until it is read.
- R8: A write of M to address 5 adds M to the count, needs no lock ownership, and saturates at MAX_COUNT (default 200). A saturating give sets the sticky overflow flag.
- R9: When a give is accepted at the same edge as a pending trial subtraction, the subtraction and its grant use the count from before the give. The give is then added to the result.
- R10: A write to address 6 loads the count with the written value clamped to MAX_COUNT and clears the overflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DW | Write data (thread id or resource number) |
| bus_rdata | output | DW | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |

## Verification
Register reads return on the edge after acceptance. The bench therefore drives each access on a falling edge and samples rdata on the next falling edge. A take is evaluated one edge after its write, so a grant read issued right behind the take lands on the evaluation edge itself. The bench uses that case on purpose to test R6. For the same-edge case of R9, a give is placed exactly one access after a take. The count is then read back later, once every update has settled.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [2:0] {
    A_LOCK_REQ = 3'd0,
    A_OWNER    = 3'd1,
    A_LOCK_REL = 3'd2,
    A_TAKE     = 3'd3,
    A_GRANT    = 3'd4,
    A_GIVE     = 3'd5,
    A_COUNT    = 3'd6,
    A_STATUS   = 3'd7
  } cs_addr_e;
endpackage

// File: rtl/cs_lock.sv
module cs_lock #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_wr,
  input  logic          rel_wr,
  input  logic [DW-1:0] id,
  output logic [DW-1:0] owner
);
  logic [DW-1:0] owner_q;
  logic          is_free;

  assign is_free = (owner_q == '0);
  assign owner   = owner_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
    end else if (req_wr && is_free) begin
      owner_q <= id;
    end else if (rel_wr && !is_free && (id == owner_q)) begin
      owner_q <= '0;
    end
  end
endmodule

// File: rtl/cs_count.sv
module cs_count #(
  parameter int DW         = 16,
  parameter int CW         = 8,
  parameter int MAX_COUNT  = 200,
  parameter int INIT_COUNT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_wr,
  input  logic          give_wr,
  input  logic          load_wr,
  input  logic          grant_rd,
  input  logic [DW-1:0] wdata,
  output logic          grant_view,
  output logic          grant,
  output logic          pending,
  output logic [CW-1:0] count,
  output logic          ovf
);
  localparam int EW = DW + 1;
  localparam logic [EW-1:0] MAXV = EW'(MAX_COUNT);

  logic [DW-1:0] req_q;
  logic          pend_q;
  logic          grant_q;
  logic [CW-1:0] count_q;
  logic          ovf_q;

  logic [EW-1:0] cnt_ext, diff, base_ext, addend, sum, next, ld;
  logic          fits, over;

  always_comb begin
    cnt_ext  = EW'(count_q);
    diff     = cnt_ext - {1'b0, req_q};
    fits     = !diff[DW];
    base_ext = (pend_q && fits) ? diff : cnt_ext;
    addend   = give_wr ? {1'b0, wdata} : '0;
    sum      = base_ext + addend;
    over     = (sum > MAXV);
    next     = over ? MAXV : sum;
    ld       = ({1'b0, wdata} > MAXV) ? MAXV : {1'b0, wdata};
  end

  assign grant_view = pend_q ? fits : grant_q;
  assign grant      = grant_q;
  assign pending    = pend_q;
  assign count      = count_q;
  assign ovf        = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      pend_q  <= 1'b0;
      grant_q <= 1'b0;
      count_q <= CW'(INIT_COUNT);
      ovf_q   <= 1'b0;
    end else begin
      pend_q <= take_wr;
      if (take_wr) req_q <= wdata;
      if (grant_rd)    grant_q <= 1'b0;
      else if (pend_q) grant_q <= fits;
      if (load_wr) begin
        count_q <= CW'(ld);
        ovf_q   <= 1'b0;
      end else begin
        count_q <= CW'(next);
        if (give_wr && over) ovf_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cnt_sema_ctrl.sv
module cnt_sema_ctrl
  import cs_pkg::*;
#(
  parameter int DW         = 16,
  parameter int CW         = 8,
  parameter int MAX_COUNT  = 200,
  parameter int INIT_COUNT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid
);
  cs_addr_e      addr;
  logic          wr, rd;
  logic          lk_req, lk_rel, take_wr, give_wr, load_wr, grant_rd;
  logic [DW-1:0] owner_q;
  logic          grant_view, grant_q, pend_q, ovf_q;
  logic [CW-1:0] count_q;

  assign addr     = cs_addr_e'(bus_addr);
  assign wr       = bus_en && bus_wr;
  assign rd       = bus_en && !bus_wr;
  assign lk_req   = wr && (addr == A_LOCK_REQ);
  assign lk_rel   = wr && (addr == A_LOCK_REL);
  assign take_wr  = wr && (addr == A_TAKE);
  assign give_wr  = wr && (addr == A_GIVE);
  assign load_wr  = wr && (addr == A_COUNT);
  assign grant_rd = rd && (addr == A_GRANT);

  cs_lock #(.DW(DW)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_wr (lk_req),
    .rel_wr (lk_rel),
    .id     (bus_wdata),
    .owner  (owner_q)
  );

  cs_count #(
    .DW(DW), .CW(CW), .MAX_COUNT(MAX_COUNT), .INIT_COUNT(INIT_COUNT)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_wr    (take_wr),
    .give_wr    (give_wr),
    .load_wr    (load_wr),
    .grant_rd   (grant_rd),
    .wdata      (bus_wdata),
    .grant_view (grant_view),
    .grant      (grant_q),
    .pending    (pend_q),
    .count      (count_q),
    .ovf        (ovf_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) begin
        case (addr)
          A_OWNER:  bus_rdata <= owner_q;
          A_GRANT:  bus_rdata <= DW'(grant_view);
          A_COUNT:  bus_rdata <= DW'(count_q);
          A_STATUS: bus_rdata <= DW'(ovf_q);
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
  parameter int DW        = 16,
  parameter int CW        = 8,
  parameter int MAX_COUNT = 200
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_wr,
  input logic [2:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_rvalid,
  input logic [DW-1:0] owner,
  input logic          grant,
  input logic          pending,
  input logic [CW-1:0] count,
  input logic          ovf
);
  a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr) |=> bus_rvalid);

  a_r2_write_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr) |=> !bus_rvalid);

  a_r3_held_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((owner != '0) && !(bus_en && bus_wr && bus_addr == 3'd2)) |=> (owner == $past(owner)));

  a_r4_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
    ((owner != '0) && bus_en && bus_wr && bus_addr == 3'd2 && bus_wdata == owner) |=> (owner == '0));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr && bus_addr == 3'd4) |=> !grant);

  a_r7_grant_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !pending && !(bus_en && !bus_wr && bus_addr == 3'd4)) |=> grant);

  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) <= MAX_COUNT));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(bus_en && bus_wr && bus_addr == 3'd6)) |=> ovf);

  a_r10_load_clears_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && bus_addr == 3'd6) |=> !ovf);
endmodule

bind cnt_sema_ctrl cs_checker #(.DW(DW), .CW(CW), .MAX_COUNT(MAX_COUNT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_en     (bus_en),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .owner      (owner_q),
  .grant      (grant_q),
  .pending    (pend_q),
  .count      (count_q),
  .ovf        (ovf_q)
);

// File: tb/tb_cnt_sema_ctrl.sv
module tb_cnt_sema_ctrl;
  localparam int DW = 16;
  localparam int NV = 37;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0;
  logic          bus_wr = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cnt_sema_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  // {req[3:0], wr, addr[2:0], wdata[15:0], expected read[15:0]}
  localparam logic [39:0] VEC [0:NV-1] = '{
    {4'd1, 1'b0, 3'd1, 16'd0,   16'd0},   // R1 owner free
    {4'd1, 1'b0, 3'd6, 16'd0,   16'd4},   // R1 count = init
    {4'd1, 1'b0, 3'd7, 16'd0,   16'd0},   // R1 no overflow
    {4'd3, 1'b1, 3'd0, 16'd5,   16'd0},   // R3 acquire id 5
    {4'd3, 1'b0, 3'd1, 16'd0,   16'd5},   // R3 owner 5
    {4'd3, 1'b1, 3'd0, 16'd9,   16'd0},   // R3 id 9 while held
    {4'd3, 1'b0, 3'd1, 16'd0,   16'd5},   // R3 still 5
    {4'd4, 1'b1, 3'd2, 16'd9,   16'd0},   // R4 wrong id release
    {4'd4, 1'b0, 3'd1, 16'd0,   16'd5},   // R4 still 5
    {4'd5, 1'b1, 3'd3, 16'd3,   16'd0},   // R5 take 3 of 4
    {4'd6, 1'b0, 3'd4, 16'd0,   16'd1},   // R6 immediate grant read
    {4'd6, 1'b0, 3'd4, 16'd0,   16'd0},   // R6 cleared by read
    {4'd5, 1'b0, 3'd6, 16'd0,   16'd1},   // R5 count 1
    {4'd4, 1'b1, 3'd2, 16'd5,   16'd0},   // R4 owner releases
    {4'd4, 1'b0, 3'd1, 16'd0,   16'd0},   // R4 free
    {4'd5, 1'b1, 3'd3, 16'd2,   16'd0},   // R5 take 2 of 1
    {4'd5, 1'b0, 3'd4, 16'd0,   16'd0},   // R5 denied
    {4'd5, 1'b0, 3'd6, 16'd0,   16'd1},   // R5 count unchanged
    {4'd8, 1'b1, 3'd5, 16'd6,   16'd0},   // R8 give 6, no lock
    {4'd8, 1'b0, 3'd6, 16'd0,   16'd7},   // R8 count 7
    {4'd9, 1'b1, 3'd3, 16'd7,   16'd0},   // R9 take 7
    {4'd9, 1'b1, 3'd5, 16'd3,   16'd0},   // R9 give 3 on eval edge
    {4'd7, 1'b1, 3'd5, 16'd1,   16'd0},   // R7 give while grant pending
    {4'd7, 1'b0, 3'd4, 16'd0,   16'd1},   // R7 grant survived
    {4'd9, 1'b0, 3'd6, 16'd0,   16'd4},   // R9 0+3+1
    {4'd10, 1'b1, 3'd6, 16'd2,  16'd0},   // R10 load 2
    {4'd9, 1'b1, 3'd3, 16'd3,   16'd0},   // R9 take 3 of 2
    {4'd9, 1'b1, 3'd5, 16'd2,   16'd0},   // R9 give 2 on eval edge
    {4'd9, 1'b0, 3'd4, 16'd0,   16'd0},   // R9 pre-give count used
    {4'd9, 1'b0, 3'd6, 16'd0,   16'd4},   // R9 count 2+2
    {4'd8, 1'b1, 3'd5, 16'd250, 16'd0},   // R8 give past max
    {4'd8, 1'b0, 3'd6, 16'd0,   16'd200}, // R8 saturated
    {4'd8, 1'b0, 3'd7, 16'd0,   16'd1},   // R8 overflow set
    {4'd10, 1'b1, 3'd6, 16'd10, 16'd0},   // R10 load 10
    {4'd10, 1'b0, 3'd7, 16'd0,  16'd0},   // R10 overflow cleared
    {4'd10, 1'b1, 3'd6, 16'd999, 16'd0},  // R10 load above max
    {4'd10, 1'b0, 3'd6, 16'd0,  16'd200}  // R10 clamped
  };

  task automatic chk(input int req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL R%0d %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic op(input bit w, input logic [2:0] a, input logic [DW-1:0] d);
    bus_en = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(1, "rvalid in reset", int'(bus_rvalid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      op(VEC[i][35], VEC[i][34:32], VEC[i][31:16]);
      if (VEC[i][35]) begin
        chk(2, $sformatf("entry %0d rvalid after write", i), int'(bus_rvalid), 0);
      end else begin
        chk(2, $sformatf("entry %0d rvalid after read", i), int'(bus_rvalid), 1);
        chk(int'(VEC[i][39:36]), $sformatf("entry %0d read", i), int'(bus_rdata), int'(VEC[i][15:0]));
      end
    end
    // R2: unmapped read addresses return 0, rvalid drops on idle cycle
    op(1'b0, 3'd3, '0);
    chk(2, "read of take address", int'(bus_rdata), 0);
    @(negedge clk);
    chk(2, "rvalid on idle cycle", int'(bus_rvalid), 0);
    // R3: id 0 while free leaves lock free, then acquire works
    op(1'b1, 3'd0, 16'd0);
    op(1'b0, 3'd1, '0);
    chk(3, "id 0 acquire", int'(bus_rdata), 0);
    op(1'b1, 3'd0, 16'd3);
    op(1'b0, 3'd1, '0);
    chk(3, "acquire id 3", int'(bus_rdata), 3);
    // R5: take exactly the whole count
    op(1'b1, 3'd6, 16'd6);
    op(1'b1, 3'd3, 16'd6);
    op(1'b0, 3'd4, '0);
    chk(5, "take all granted", int'(bus_rdata), 1);
    op(1'b0, 3'd6, '0);
    chk(5, "count empty", int'(bus_rdata), 0);
    // R1: reset mid-run restores everything
    op(1'b1, 3'd5, 16'd250);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    op(1'b0, 3'd6, '0);
    chk(1, "count after reset", int'(bus_rdata), 4);
    op(1'b0, 3'd1, '0);
    chk(1, "owner after reset", int'(bus_rdata), 0);
    op(1'b0, 3'd7, '0);
    chk(1, "overflow after reset", int'(bus_rdata), 0);
    op(1'b0, 3'd4, '0);
    chk(1, "grant after reset", int'(bus_rdata), 0);
    finish_run();
  end
endmodule